// File: doc/BRIEF.md
# Row-Indexed Memory Test Word Generator

This block turns a test request into a 64-bit data word for a memory or register-file test engine. Each request carries a row index, a three-bit pattern selector and an invert flag, and comes with a valid strobe. The block scales the row index into a byte offset, evaluates the selected pattern for that offset, and presents the word on a registered output one clock after the request.

Six pattern families are available. Some are constant, some are striped and some depend on the row, including a walking single bit and a byte sequence taken modulo 257. Most of them also have an inverted variant. The test engine that drives the block keeps track of addresses, performs the reads and writes, and compares the data. This block supplies only the expected or stimulus word.

Top module: `tpg_top`

## Requirements
- R1: After reset `out_valid`, `out_error` and `out_data` are zero. `out_valid` equals the `req_valid` value sampled at the previous rising clock edge, so the word for a request appears exactly one cycle later.
- R2: Pattern code 0 (incrementing bytes): with offset = row × 8, byte lane i (bits 8i+7..8i) holds (offset + i) mod 256, and the invert flag has no effect.
- R3: Pattern code 1 (uniform): the word is all zeros, or all ones when inverted, for any row.
- R4: Pattern code 2 (bit stripes): both 32-bit halves hold 0xAAAAAAAA, or 0x55555555 when inverted.
- R5: Pattern code 3 (byte stripes): both 32-bit halves hold 0xFF00FF00, or 0x00FF00FF when inverted.
- R6: Pattern code 4 (changing byte), offset below 256: all eight lanes hold offset mod 256. Inversion complements the byte.
- R7: Pattern code 4, offset of 256 or more: all eight lanes hold the complement of the low 8 bits of ((offset − 8) mod 257). Inversion complements the byte.
- R8: Pattern code 5 (walking bit): the word is zero except for a single one at bit (offset / 8) mod 64. When inverted the word is all ones with that single bit cleared.
- R9: Pattern codes 6 and 7 give an all-zero word with `out_error` high for that one output cycle. Valid codes give `out_error` low.
- R10: In a cycle after `req_valid` was low, `out_data` keeps its previous value and `out_error` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_row | input | 16 | Row index of the request |
| req_pattern | input | 3 | Pattern selector, codes 0..5 valid |
| req_negate | input | 1 | Selects the inverted variant |
| out_valid | output | 1 | Word for the previous cycle's request is present |
| out_data | output | 64 | Generated test word |
| out_error | output | 1 | Previous request used an undefined pattern code |

## Verification
The assertions assume that `req_row`, `req_pattern` and `req_negate` have known values in every cycle where `req_valid` is high, and that `req_valid` is low while reset is active. The bench drives all request inputs on the falling edge and holds `req_valid` low through reset. Its random stimulus covers all eight selector codes, including the two undefined ones, full-range rows and random idle cycles. Directed requests land on the rows around offset 256, where the changing-byte formula switches, on the row where the walking bit wraps, and on the largest row.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int WORD_W  = 64;
    localparam int LANE_W  = 8;
    localparam int N_LANES = WORD_W / LANE_W;

    typedef enum logic [2:0] {
        PAT_INCR    = 3'd0,
        PAT_UNIFORM = 3'd1,
        PAT_BITSTR  = 3'd2,
        PAT_BYTESTR = 3'd3,
        PAT_CHANGE  = 3'd4,
        PAT_WALK    = 3'd5
    } pat_e;

    typedef struct packed {
        logic              valid;
        logic              error;
        logic [WORD_W-1:0] data;
    } out_state_t;

endpackage

// File: rtl/tpg_offset.sv
module tpg_offset #(
    parameter int ROW_W    = 16,
    parameter int ROW_STEP = 8,
    parameter int OFF_W    = ROW_W + $clog2(ROW_STEP + 1)
) (
    input  logic [ROW_W-1:0] row,
    output logic [OFF_W-1:0] offset
);
    // Row scaled by the fixed step; widened so no bits are lost.
    always_comb begin
        offset = OFF_W'(row) * OFF_W'(ROW_STEP);
    end
endmodule

// File: rtl/tpg_pattern.sv
module tpg_pattern
    import tpg_pkg::*;
#(
    parameter int OFF_W = 20
) (
    input  logic [OFF_W-1:0]  offset,
    input  logic [2:0]        pattern,
    input  logic              negate,
    output logic [WORD_W-1:0] word,
    output logic              invalid
);
    localparam int MODULUS  = 257;
    localparam int WALK_W   = $clog2(WORD_W);
    localparam int BYTE_SH  = $clog2(LANE_W);

    logic [WORD_W-1:0] incr_word;
    logic [LANE_W-1:0] change_byte;
    logic [OFF_W-1:0]  shifted;
    logic [OFF_W-1:0]  residue;
    logic [WALK_W-1:0] walk_pos;
    logic [WORD_W-1:0] walk_word;

    // One adder per lane for the incrementing-byte pattern.
    for (genvar lane = 0; lane < N_LANES; lane++) begin : g_lane
        assign incr_word[lane*LANE_W +: LANE_W] =
            offset[LANE_W-1:0] + LANE_W'(lane);
    end

    // Changing byte: below 256 the offset itself, above it the
    // complement of the shifted residue modulo 257.
    always_comb begin
        shifted = offset - OFF_W'(8);
        residue = shifted % OFF_W'(MODULUS);
        if (offset < OFF_W'(256)) begin
            change_byte = offset[LANE_W-1:0];
        end else begin
            change_byte = ~residue[LANE_W-1:0];
        end
        if (negate) begin
            change_byte = ~change_byte;
        end
    end

    // Walking bit position taken from the byte offset in 8-byte units.
    always_comb begin
        walk_pos  = offset[BYTE_SH +: WALK_W];
        walk_word = '0;
        walk_word[walk_pos] = 1'b1;
        if (negate) begin
            walk_word = ~walk_word;
        end
    end

    always_comb begin
        invalid = 1'b0;
        word    = '0;
        case (pattern)
            PAT_INCR:    word = incr_word;
            PAT_UNIFORM: word = negate ? '1 : '0;
            PAT_BITSTR:  word = negate ? {2{32'h5555_5555}} : {2{32'hAAAA_AAAA}};
            PAT_BYTESTR: word = negate ? {2{32'h00FF_00FF}} : {2{32'hFF00_FF00}};
            PAT_CHANGE:  word = {N_LANES{change_byte}};
            PAT_WALK:    word = walk_word;
            default: begin
                word    = '0;
                invalid = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/tpg_top.sv
module tpg_top
    import tpg_pkg::*;
#(
    parameter int ROW_W    = 16,
    parameter int ROW_STEP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [2:0]        req_pattern,
    input  logic              req_negate,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_error
);
    localparam int OFF_W = ROW_W + $clog2(ROW_STEP + 1);

    logic [OFF_W-1:0]  offset;
    logic [WORD_W-1:0] gen_word;
    logic              gen_invalid;
    out_state_t        st_d, st_q;

    tpg_offset #(
        .ROW_W    (ROW_W),
        .ROW_STEP (ROW_STEP),
        .OFF_W    (OFF_W)
    ) u_offset (
        .row    (req_row),
        .offset (offset)
    );

    tpg_pattern #(
        .OFF_W (OFF_W)
    ) u_pattern (
        .offset  (offset),
        .pattern (req_pattern),
        .negate  (req_negate),
        .word    (gen_word),
        .invalid (gen_invalid)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = req_valid;
        st_d.error = 1'b0;
        if (req_valid) begin
            st_d.data  = gen_word;
            st_d.error = gen_invalid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_data  = st_q.data;
    assign out_error = st_q.error;

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);
    assert_uniform_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_pattern == 3'd1) |=> (out_data == '0 || out_data == '1));
    assert_change_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_pattern == 3'd4) |=> (out_data == {N_LANES{out_data[7:0]}}));
    assert_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_pattern == 3'd5 && !req_negate) |=> ($countones(out_data) == 1));
    assert_walk_neg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_pattern == 3'd5 && req_negate) |=> ($countones(~out_data) == 1));
    assert_bad_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_pattern > 3'd5) |=> (out_error && out_data == '0));
    assert_error_qual_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_error |-> out_valid);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !req_valid) |=> $stable(out_data));
endmodule

// File: tb/tpg_top_tb.sv
module tpg_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_row = '0;
    logic [2:0]  req_pattern = '0;
    logic        req_negate = 1'b0;
    logic        out_valid;
    logic [63:0] out_data;
    logic        out_error;

    int checks = 0;
    int errors = 0;
    logic [63:0] last_word = '0;

    always #4 clk = ~clk;

    tpg_top u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_row     (req_row),
        .req_pattern (req_pattern),
        .req_negate  (req_negate),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_error   (out_error)
    );

    function automatic logic [63:0] ref_word(input int row, input int pat, input bit neg);
        int off;
        logic [7:0] b;
        logic [63:0] w;
        off = row * 8;
        w = '0;
        case (pat)
            0: for (int i = 0; i < 8; i++) w[i*8 +: 8] = 8'((off + i) % 256);
            1: w = neg ? {64{1'b1}} : 64'd0;
            2: w = neg ? 64'h5555555555555555 : 64'hAAAAAAAAAAAAAAAA;
            3: w = neg ? 64'h00FF00FF00FF00FF : 64'hFF00FF00FF00FF00;
            4: begin
                if (off / 256 == 0) b = 8'((off % 257) % 256);
                else b = ~8'((off - 8) % 257);
                if (neg) b = ~b;
                for (int i = 0; i < 8; i++) w[i*8 +: 8] = b;
            end
            5: begin
                w[(off / 8) % 64] = 1'b1;
                if (neg) w = ~w;
            end
            default: w = '0;
        endcase
        return w;
    endfunction

    function automatic string tag_of(input int row, input int pat);
        case (pat)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return (row * 8 < 256) ? "R6" : "R7";
            5: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drive on falling edge, sample on the following falling edge.
    task automatic request(input int row, input int pat, input bit neg);
        logic [63:0] exp;
        string tag;
        req_valid   = 1'b1;
        req_row     = 16'(row);
        req_pattern = 3'(pat);
        req_negate  = neg;
        @(negedge clk);
        tag = tag_of(row, pat);
        exp = ref_word(row, pat, neg);
        check("R1", "valid", 64'(out_valid), 64'd1);
        check(tag, "data", out_data, exp);
        check(tag, "error", 64'(out_error), (pat > 5) ? 64'd1 : 64'd0);
        last_word = out_data;
    endtask

    task automatic idle();
        req_valid   = 1'b0;
        req_row     = 16'hFFFF;
        req_pattern = 3'd1;
        req_negate  = 1'b1;
        @(negedge clk);
        check("R10", "hold data", out_data, last_word);
        check("R10", "error low", 64'(out_error), 64'd0);
        check("R1", "valid low", 64'(out_valid), 64'd0);
    endtask

    initial begin : watchdog
        #1600000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1", "reset valid", 64'(out_valid), 64'd0);
        check("R1", "reset data", out_data, 64'd0);
        check("R1", "reset error", 64'(out_error), 64'd0);
        rst_n = 1'b1;

        // Directed corners
        request(0, 0, 1'b0);
        request(31, 0, 1'b1);
        request(5, 1, 1'b0);
        request(9000, 1, 1'b1);
        request(3, 2, 1'b0);
        request(3, 2, 1'b1);
        request(7, 3, 1'b0);
        request(7, 3, 1'b1);
        request(0, 4, 1'b0);
        request(31, 4, 1'b0);
        request(31, 4, 1'b1);
        request(32, 4, 1'b0);
        request(33, 4, 1'b1);
        request(65535, 4, 1'b0);
        request(0, 5, 1'b0);
        request(63, 5, 1'b0);
        request(64, 5, 1'b1);
        request(65535, 5, 1'b1);
        request(100, 6, 1'b0);
        request(100, 7, 1'b1);
        idle();
        request(12, 2, 1'b0);
        request(12, 7, 1'b0);
        idle();

        // Random mix
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 4) == 0) begin
                idle();
            end else begin
                request(int'($urandom_range(0, 65535)), int'($urandom_range(0, 7)),
                        1'($urandom_range(0, 1)));
            end
        end

        idle();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule